// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller

This block controls one port of eight general-purpose pins and exposes them to software through a small word-addressed register bus. Each pin has its own window of eight register words. Software uses it to enable the pin, to pick its direction, to float or drive the pad, and to set the level it drives. The pad level reaches software through a two-flop synchroniser.

Each pin can also raise an interrupt. A two-bit trigger type and a polarity bit select level, single-edge or double-edge detection. A detected event latches into a per-pin status bit, and a write to that pin's clear register releases it. One status word gathers the eight status bits, and their OR drives a single interrupt line.

The debounce-enable and timestamp-enable bits, and the debounce threshold word, are stored and read back but have no effect on the pin. All registers clear on reset, so every pin starts disabled and undriven.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is all zeros and `irq` is 0.
- R2: Word address `p*8 + k` reaches pin p's register k. The values of k are: 0 configuration (8 bits), 1 debounce threshold (DBNC_W bits), 2 pad input (read-only), 3 float control (bit 0), 4 drive level (bit 0), 5 status clear (write-only, reads 0). Word `NUM_PINS*8` (byte offset 0x100 at defaults) is the read-only status word. Every other word reads 0, and writes to it are dropped.
- R3: The configuration bits are: bit 0 enable, bit 1 output direction, bits 3:2 trigger type (0 none, 1 level, 2 single edge, 3 double edge), bit 4 high/rising polarity, bit 5 debounce enable, bit 6 interrupt enable, bit 7 timestamp enable. Bits 5 and 7 are stored only and change neither drive nor detection.
- R4: `pad_oe[p]` is 1 exactly when pin p is enabled, set to output and its float bit is 0. While `pad_oe[p]` is 1, `pad_out[p]` equals the drive-level bit; otherwise it is 0.
- R5: The pad input word returns, in bit 0, the pad sampled through two flops. A pad change made before clock edge n shows on the bus after edge n+1. It shows the pad even for an output pin, whose driven level is read from the drive-level word.
- R6: With trigger type level, status sets on each cycle in which the synchronised input equals the polarity bit.
- R7: With trigger type single edge, status latches on a rising edge of the synchronised input when polarity is 1, and on a falling edge when polarity is 0. The opposite edge is ignored.
- R8: With trigger type double edge, status latches on either edge of the synchronised input.
- R9: Status is set only while both the enable bit and the interrupt-enable bit are 1. Trigger type none never sets it.
- R10: Writing a word with bit 0 set to a pin's clear register clears its status at that edge, winning over a same-cycle event. A level condition that is still present sets status again one cycle later. A clear write with bit 0 at 0 has no effect.
- R11: Bit p of the status word is pin p's status, and `irq` is the OR of all status bits. Writes to the status word or to a pad input word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| pad_in | input | NUM_PINS | Pad levels (asynchronous) |
| pad_out | output | NUM_PINS | Driven pad levels |
| pad_oe | output | NUM_PINS | Pad drive enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its defaults: eight pins, a 32-bit data word, a 16-bit debounce threshold and a 7-bit word address. These settings place the status word at word 64 (byte 0x100), directly above the last pin window, so the tests reach the boundary between the pin windows and the status word, and the unmapped words above it. The 16-bit threshold is narrower than the data word, so a write of all ones shows that the read-back is truncated. With eight pins, several pins can be pending at once, which tests the aggregate line while their bits are cleared one by one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      TRIG_NONE   = 2'd0,
      TRIG_LEVEL  = 2'd1,
      TRIG_SINGLE = 2'd2,
      TRIG_DOUBLE = 2'd3
   } trig_e;

   // Field order is decoded by software: bit 0 at the bottom.
   typedef struct packed {
      logic  tstamp_en;
      logic  irq_en;
      logic  dbnc_en;
      logic  pol_hi;
      trig_e trig;
      logic  dir_out;
      logic  en;
   } pin_cfg_t;

   localparam int unsigned CFG_W  = $bits(pin_cfg_t);
   localparam int unsigned REG_AW = 3;            // 8 words per pin window

   localparam logic [REG_AW-1:0] OFS_CFG   = 3'd0;
   localparam logic [REG_AW-1:0] OFS_DBNC  = 3'd1;
   localparam logic [REG_AW-1:0] OFS_PAD   = 3'd2;
   localparam logic [REG_AW-1:0] OFS_FLOAT = 3'd3;
   localparam logic [REG_AW-1:0] OFS_LEVEL = 3'd4;
   localparam logic [REG_AW-1:0] OFS_CLR   = 3'd5;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_port_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DBNC_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pad_in,
   input  logic              wr_cfg,
   input  logic              wr_dbnc,
   input  logic              wr_float,
   input  logic              wr_level,
   input  logic              wr_clr,
   input  logic [DATA_W-1:0] wdata,
   output pin_cfg_t          cfg_q,
   output logic [DBNC_W-1:0] dbnc_q,
   output logic              float_q,
   output logic              level_q,
   output logic              pin_sync,
   output logic              stat_q,
   output logic              pad_oe,
   output logic              pad_out
);
   logic sync_d, rise, fall, hit, armed, clr_now;

   gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         dbnc_q  <= '0;
         float_q <= 1'b0;
         level_q <= 1'b0;
         sync_d  <= 1'b0;
      end else begin
         sync_d <= pin_sync;
         if (wr_cfg)   cfg_q   <= pin_cfg_t'(wdata[CFG_W-1:0]);
         if (wr_dbnc)  dbnc_q  <= wdata[DBNC_W-1:0];
         if (wr_float) float_q <= wdata[0];
         if (wr_level) level_q <= wdata[0];
      end
   end

   assign pad_oe  = cfg_q.en & cfg_q.dir_out & ~float_q;
   assign pad_out = pad_oe & level_q;

   assign rise    = pin_sync & ~sync_d;
   assign fall    = ~pin_sync & sync_d;
   assign armed   = cfg_q.en & cfg_q.irq_en;
   assign clr_now = wr_clr & wdata[0];

   always_comb begin
      unique case (cfg_q.trig)
         TRIG_LEVEL:  hit = (pin_sync == cfg_q.pol_hi);
         TRIG_SINGLE: hit = cfg_q.pol_hi ? rise : fall;
         TRIG_DOUBLE: hit = rise | fall;
         default:     hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             stat_q <= 1'b0;
      else if (clr_now)       stat_q <= 1'b0;
      else if (armed && hit)  stat_q <= 1'b1;
   end

   // R4: the drive enable only turns on after a configuration or float write
   a_r4_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_oe) |-> $past(wr_cfg || wr_float));

   // R10: a clear with bit 0 set leaves status low after the edge
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && wdata[0]) |=> !stat_q);

   // R9: status never rises out of a disarmed cycle
   a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_q.en && cfg_q.irq_en) |=> !$rose(stat_q));

   // R6: a matching level with no clear latches status
   a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cfg_q.trig == TRIG_LEVEL && pin_sync == cfg_q.pol_hi && !wr_clr)
      |=> stat_q);

   // R8: any change of the synchronised pin latches a double-edge trigger
   a_r8_double_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cfg_q.trig == TRIG_DOUBLE && pin_sync != sync_d && !wr_clr)
      |=> stat_q);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DBNC_W      = 16,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);
   localparam int unsigned PIN_AW      = ADDR_W - REG_AW;
   localparam int unsigned STATUS_WORD = NUM_PINS << REG_AW;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_port_ctrl: NUM_PINS must be 1..DATA_W");
   end
   if (DATA_W < CFG_W || DBNC_W < 1 || DBNC_W > DATA_W) begin : g_bad_width
      $error("gpio_port_ctrl: DATA_W must hold the config and threshold words");
   end
   if (ADDR_W <= REG_AW || STATUS_WORD >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_port_ctrl: ADDR_W too small for the status word");
   end

   logic [PIN_AW-1:0] pin_idx;
   logic [REG_AW-1:0] reg_sel;
   assign pin_idx = bus_addr[ADDR_W-1:REG_AW];
   assign reg_sel = bus_addr[REG_AW-1:0];

   pin_cfg_t          cfg_arr   [NUM_PINS];
   logic [DBNC_W-1:0] dbnc_arr  [NUM_PINS];
   logic [NUM_PINS-1:0] float_vec, level_vec, sync_vec, stat_vec;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel;
      assign sel = bus_we && (pin_idx == PIN_AW'(p));

      gpio_pin_cell #(
         .DATA_W(DATA_W), .DBNC_W(DBNC_W), .SYNC_STAGES(SYNC_STAGES)
      ) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .pad_in   (pad_in[p]),
         .wr_cfg   (sel && reg_sel == OFS_CFG),
         .wr_dbnc  (sel && reg_sel == OFS_DBNC),
         .wr_float (sel && reg_sel == OFS_FLOAT),
         .wr_level (sel && reg_sel == OFS_LEVEL),
         .wr_clr   (sel && reg_sel == OFS_CLR),
         .wdata    (bus_wdata),
         .cfg_q    (cfg_arr[p]),
         .dbnc_q   (dbnc_arr[p]),
         .float_q  (float_vec[p]),
         .level_q  (level_vec[p]),
         .pin_sync (sync_vec[p]),
         .stat_q   (stat_vec[p]),
         .pad_oe   (pad_oe[p]),
         .pad_out  (pad_out[p])
      );
   end

   assign irq = |stat_vec;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(STATUS_WORD)) begin
         bus_rdata[NUM_PINS-1:0] = stat_vec;
      end else begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_idx == PIN_AW'(p)) begin
               case (reg_sel)
                  OFS_CFG:   bus_rdata[CFG_W-1:0]  = cfg_arr[p];
                  OFS_DBNC:  bus_rdata[DBNC_W-1:0] = dbnc_arr[p];
                  OFS_PAD:   bus_rdata[0]          = sync_vec[p];
                  OFS_FLOAT: bus_rdata[0]          = float_vec[p];
                  OFS_LEVEL: bus_rdata[0]          = level_vec[p];
                  default:   bus_rdata             = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
   localparam int NP = 8;
   localparam int STAT = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
   logic        irq;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   function automatic int wa(int pin, int ofs);
      return pin * 8 + ofs;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [31:0] d);
      bus_addr = 7'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_addr = 7'(a);
      #1 d = bus_rdata;
   endtask

   task automatic chk_rd(string req, string what, int a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, what, d, exp);
   endtask

   task automatic t_reset;
      chk("R1", "pad_oe", 32'(pad_oe), 0);
      chk("R1", "irq", 32'(irq), 0);
      chk_rd("R1", "cfg pin0", wa(0, 0), 0);
      chk_rd("R1", "level pin7", wa(7, 4), 0);
      chk_rd("R1", "status", STAT, 0);
   endtask

   task automatic t_regmap;
      wr(wa(3, 0), 32'hA5);
      chk_rd("R2", "cfg pin3", wa(3, 0), 32'hA5);
      wr(wa(5, 1), 32'h1234);
      chk_rd("R2", "dbnc pin5", wa(5, 1), 32'h1234);
      wr(wa(5, 1), 32'hFFFF_FFFF);
      chk_rd("R2", "dbnc width", wa(5, 1), 32'hFFFF);
      wr(wa(1, 6), 32'hFFFF_FFFF);
      chk_rd("R2", "unmapped word", wa(1, 6), 0);
      chk_rd("R2", "clear reads 0", wa(1, 5), 0);
      chk_rd("R2", "above status", STAT + 1, 0);
      wr(wa(1, 2), 1);
      chk_rd("R11", "pad word ignores write", wa(1, 2), 0);
      // R3: debounce/timestamp bits with ie+en and trigger none do nothing
      wr(wa(0, 0), 32'hE1);
      chk_rd("R3", "cfg readback", wa(0, 0), 32'hE1);
      pad_in[0] = 1'b1; tick(4); pad_in[0] = 1'b0; tick(4);
      chk_rd("R3", "no status from stored bits", STAT, 0);
      chk("R3", "no drive", 32'(pad_oe), 0);
      wr(wa(0, 0), 0);
   endtask

   task automatic t_drive;
      wr(wa(2, 0), 32'h03);
      wr(wa(2, 4), 1);
      chk("R4", "oe driving", 32'(pad_oe), 32'h04);
      chk("R4", "out driving", 32'(pad_out), 32'h04);
      chk_rd("R5", "level word", wa(2, 4), 1);
      chk_rd("R5", "pad word of output", wa(2, 2), 0);
      wr(wa(2, 3), 1);
      chk("R4", "oe floated", 32'(pad_oe), 0);
      chk("R4", "out floated", 32'(pad_out), 0);
      chk_rd("R2", "float readback", wa(2, 3), 1);
      wr(wa(2, 3), 0);
      chk("R4", "oe unfloated", 32'(pad_oe), 32'h04);
      wr(wa(2, 0), 32'h02);
      chk("R4", "oe disabled", 32'(pad_oe), 0);
      wr(wa(2, 0), 32'h01);
      chk("R4", "oe input dir", 32'(pad_oe), 0);
      wr(wa(2, 0), 0); wr(wa(2, 4), 0);
   endtask

   task automatic t_sync;
      pad_in[1] = 1'b1;
      tick(1);
      chk_rd("R5", "pad after 1 edge", wa(1, 2), 0);
      tick(1);
      chk_rd("R5", "pad after 2 edges", wa(1, 2), 1);
      pad_in[1] = 1'b0; tick(2);
      chk_rd("R5", "pad low again", wa(1, 2), 0);
   endtask

   task automatic t_level;
      wr(wa(4, 0), 32'h55);
      chk_rd("R6", "level low no set", STAT, 0);
      pad_in[4] = 1'b1; tick(3);
      chk_rd("R6", "level high set", STAT, 32'h10);
      chk("R11", "irq level", 32'(irq), 1);
      wr(wa(4, 5), 1);
      chk_rd("R10", "clear wins", STAT, 0);
      tick(1);
      chk_rd("R10", "level re-sets", STAT, 32'h10);
      pad_in[4] = 1'b0; tick(3);
      wr(wa(4, 5), 1); tick(1);
      chk_rd("R10", "cleared stays clear", STAT, 0);
      wr(wa(4, 0), 32'h45); tick(1);
      chk_rd("R6", "active-low level", STAT, 32'h10);
      wr(wa(4, 0), 0); wr(wa(4, 5), 1);
      chk_rd("R6", "cleanup", STAT, 0);
   endtask

   task automatic t_single;
      wr(wa(6, 0), 32'h59);
      pad_in[6] = 1'b1; tick(3);
      chk_rd("R7", "rising sets", STAT, 32'h40);
      wr(wa(6, 5), 1); tick(2);
      chk_rd("R7", "edge not re-set", STAT, 0);
      pad_in[6] = 1'b0; tick(4);
      chk_rd("R7", "falling ignored", STAT, 0);
      wr(wa(6, 0), 32'h49);
      pad_in[6] = 1'b1; tick(4);
      chk_rd("R7", "rising ignored", STAT, 0);
      pad_in[6] = 1'b0; tick(3);
      chk_rd("R7", "falling sets", STAT, 32'h40);
      wr(wa(6, 0), 0); wr(wa(6, 5), 1);
   endtask

   task automatic t_double;
      wr(wa(7, 0), 32'h4D);
      pad_in[7] = 1'b1; tick(3);
      chk_rd("R8", "double rise", STAT, 32'h80);
      wr(wa(7, 5), 1);
      pad_in[7] = 1'b0; tick(3);
      chk_rd("R8", "double fall", STAT, 32'h80);
      wr(wa(7, 0), 0); wr(wa(7, 5), 1);
      chk_rd("R8", "cleanup", STAT, 0);
   endtask

   task automatic t_gating;
      wr(wa(0, 0), 32'h0D);
      pad_in[0] = 1'b1; tick(4); pad_in[0] = 1'b0; tick(4);
      chk_rd("R9", "no irq enable", STAT, 0);
      wr(wa(0, 0), 32'h4C);
      pad_in[0] = 1'b1; tick(4); pad_in[0] = 1'b0; tick(4);
      chk_rd("R9", "pin disabled", STAT, 0);
      wr(wa(0, 0), 32'h41);
      pad_in[0] = 1'b1; tick(4); pad_in[0] = 1'b0; tick(4);
      chk_rd("R9", "trigger none", STAT, 0);
      chk("R9", "irq quiet", 32'(irq), 0);
      wr(wa(0, 0), 0);
   endtask

   task automatic t_aggregate;
      wr(wa(5, 0), 32'h4D); wr(wa(3, 0), 32'h4D);
      pad_in[5] = 1'b1; pad_in[3] = 1'b1; tick(3);
      chk_rd("R11", "two pending", STAT, 32'h28);
      wr(wa(5, 5), 32'h2);
      chk_rd("R10", "clear bit0 zero ignored", STAT, 32'h28);
      wr(STAT, 0);
      chk_rd("R11", "status write ignored", STAT, 32'h28);
      wr(wa(5, 5), 1);
      chk_rd("R11", "one cleared", STAT, 32'h08);
      chk("R11", "irq still up", 32'(irq), 1);
      wr(wa(3, 5), 1);
      chk_rd("R11", "all cleared", STAT, 0);
      chk("R11", "irq down", 32'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_regmap();
      t_drive();
      t_sync();
      t_level();
      t_single();
      t_double();
      t_gating();
      t_aggregate();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule